// File: doc/BRIEF.md
# Strobed Control Register Bank

This block is the receiving end of a narrow parallel control path. A host shares one 8-bit data bus among three latched control registers: system control, monitor routing, and clock/source selection. To write a register, the host drives the bus and pulls a common active-low output enable. It then drives the chosen register's active-low strobe low and releases it. The register takes the bus value on the release, which is the rising edge of the strobe.

The bus, the output enable and the three strobes are all asynchronous to the system clock. They pass through synchronizers, and the strobe rising edges are detected in the clock domain. A strobe released while the output enable is high changes nothing.

The clock/source register uses a packed encoding. Its rate field gives an internal sample rate, or helps name the external sync source when the sync bit is set. The block decodes this register into a rate index, a sync-source type and an illegal-code flag.

Top module: `strobed_reg_bank`

## Requirements
- R1: After reset, all three registers read 0x00, `rateIdx` is 0, `rateValid` is 1, `syncType` is 0 (internal) and `illegalCode` is 0.
- R2: When a strobe rises while output enable is low, the targeted register takes the bus value. With the default two synchronizer stages, the new value appears on the outputs after the third rising clock edge that samples the strobe high.
- R3: A strobe rise while output enable is high leaves every register unchanged.
- R4: A write through one strobe leaves the other two registers unchanged.
- R5: `sysCtrl` presents the system register bits unchanged: bit 0 mic relay, bit 1 phantom 48 V select, bit 2 mute, bit 3 phantom off, bits 5:4 input 1/2 source, bit 6 input 3/4 hi-Z, bit 7 codec run.
- R6: `monRoutes` presents monitor register bits 5:0, one route enable each. Bus bits 7:6 on a monitor write are discarded.
- R7: `rateIdx` equals clock register bits 2:0 (0 = 44.1 kHz, 1 = 48, 2 = 88.2, 3 = 96, 4 = 176.4, 5 = 192 kHz). `rateValid` is 1 only when bit 3 (sync) is 0 and the code is 5 or less.
- R8: With bit 3 set, clock register bits 4:0 decode as follows, whatever bits 7:5 hold: 5'b01000 gives `syncType` 1 (S/PDIF), 5'b01010 gives 2 (word clock 1·fs), and 5'b11010 gives 3 (word clock 256·fs).
- R9: `illegalCode` is 1 in two cases: an external code with any other bits 4:0 pattern, or an internal rate code of 6 or 7. An illegal code reports `syncType` 0 and `rateValid` 0.
- R10: Driving a strobe low, or holding it low, never changes a register. Only the release does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busData | input | 8 | Shared parallel data bus |
| busOeN | input | 1 | Active-low output enable gating all strobes |
| sysStbN | input | 1 | Active-low strobe, system control register |
| monStbN | input | 1 | Active-low strobe, monitor routing register |
| clkStbN | input | 1 | Active-low strobe, clock/source register |
| sysCtrl | output | 8 | System control register contents |
| monRoutes | output | 6 | Monitor route enables |
| clkCtrl | output | 8 | Clock/source register contents |
| rateIdx | output | 3 | Internal rate code |
| rateValid | output | 1 | Internal sync with a defined rate |
| syncType | output | 2 | 0 internal, 1 S/PDIF, 2 word clock 1·fs, 3 word clock 256·fs |
| illegalCode | output | 1 | Clock register holds an undefined combination |

## Verification
The hardest case to reach is a strobe edge whose qualifying conditions straddle the synchronizer latency. Examples are a release with output enable high, or a strobe held low for many cycles. Only a release seen two samples late should commit, using the bus value sampled at that same moment. The bench drives full host write sequences and also gated, long-held and randomly mixed sequences on all three strobes. A behavioural model replays the pin history to predict the exact commit cycle and the decoded clock fields on every clock.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int NUM_STB = 3;
  localparam int STB_SYS = 0;
  localparam int STB_MON = 1;
  localparam int STB_CLK = 2;
  localparam int RATE_W = 3;
  localparam int RATE_MAX = 5;
  localparam int SYNC_BIT = 3;
  localparam int CODE_W = 5;
  localparam logic [CODE_W-1:0] CODE_SPDIF = 5'b01000;
  localparam logic [CODE_W-1:0] CODE_WC1 = 5'b01010;
  localparam logic [CODE_W-1:0] CODE_WC256 = 5'b11010;

  typedef enum logic [1:0] {
    SYNC_INT = 2'd0,
    SYNC_SPDIF = 2'd1,
    SYNC_WC1 = 2'd2,
    SYNC_WC256 = 2'd3
  } sync_e;

  typedef struct packed {
    logic sysWr;
    logic monWr;
    logic clkWr;
  } wrStrobe_t;
endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic [DATA_W-1:0] busData,
  input  logic busOeN,
  input  logic [NUM_STB-1:0] stbN,
  output wrStrobe_t wr,
  output logic [DATA_W-1:0] wrData
);
  logic [NUM_STB-1:0][SYNC_STAGES-1:0] stbPipe;
  logic [NUM_STB-1:0] stbLast;
  logic [SYNC_STAGES-1:0] oePipe;
  logic [SYNC_STAGES-1:0][DATA_W-1:0] dataPipe;
  logic [NUM_STB-1:0] rise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbPipe <= '1;
      stbLast <= '1;
      oePipe <= '1;
      dataPipe <= '0;
    end else begin
      for (int i = 0; i < NUM_STB; i++) begin
        stbPipe[i] <= {stbPipe[i][SYNC_STAGES-2:0], stbN[i]};
        stbLast[i] <= stbPipe[i][SYNC_STAGES-1];
      end
      oePipe <= {oePipe[SYNC_STAGES-2:0], busOeN};
      dataPipe <= {dataPipe[SYNC_STAGES-2:0], busData};
    end
  end

  for (genvar g = 0; g < NUM_STB; g++) begin : g_edge
    assign rise[g] = stbPipe[g][SYNC_STAGES-1] & ~stbLast[g] & ~oePipe[SYNC_STAGES-1];
  end

  always_comb begin
    wr.sysWr = rise[STB_SYS];
    wr.monWr = rise[STB_MON];
    wr.clkWr = rise[STB_CLK];
  end

  assign wrData = dataPipe[SYNC_STAGES-1];

  // R10: a release produces one write pulse, never a held write
  a_r10_sys_single: assert property (@(posedge clk) disable iff (!rstN)
    wr.sysWr |=> !wr.sysWr);
  a_r10_clk_single: assert property (@(posedge clk) disable iff (!rstN)
    wr.clkWr |=> !wr.clkWr);
endmodule

// File: rtl/regbank_dp.sv
module regbank_dp
  import regbank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MON_W = 6
) (
  input  logic clk,
  input  logic rstN,
  input  wrStrobe_t wr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] sysReg,
  output logic [MON_W-1:0] monReg,
  output logic [DATA_W-1:0] clkReg,
  output logic [RATE_W-1:0] rateIdx,
  output logic rateValid,
  output sync_e syncType,
  output logic illegalCode
);
  logic extSync;
  logic [CODE_W-1:0] clkCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysReg <= '0;
      monReg <= '0;
      clkReg <= '0;
    end else begin
      if (wr.sysWr) sysReg <= wrData;
      if (wr.monWr) monReg <= wrData[MON_W-1:0];
      if (wr.clkWr) clkReg <= wrData;
    end
  end

  assign extSync = clkReg[SYNC_BIT];
  assign clkCode = clkReg[CODE_W-1:0];
  assign rateIdx = clkReg[RATE_W-1:0];

  always_comb begin
    syncType = SYNC_INT;
    illegalCode = 1'b0;
    rateValid = 1'b0;
    if (!extSync) begin
      rateValid = (int'(clkReg[RATE_W-1:0]) <= RATE_MAX);
      illegalCode = !rateValid;
    end else begin
      unique case (clkCode)
        CODE_SPDIF: syncType = SYNC_SPDIF;
        CODE_WC1: syncType = SYNC_WC1;
        CODE_WC256: syncType = SYNC_WC256;
        default: illegalCode = 1'b1;
      endcase
    end
  end

  // R2: a write pulse commits the synchronized bus value
  a_r2_sys_capture: assert property (@(posedge clk) disable iff (!rstN)
    wr.sysWr |=> sysReg == $past(wrData));
  a_r2_clk_capture: assert property (@(posedge clk) disable iff (!rstN)
    wr.clkWr |=> clkReg == $past(wrData));
  // R4: registers hold without their own pulse
  a_r4_sys_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wr.sysWr |=> $stable(sysReg));
  a_r4_mon_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wr.monWr |=> $stable(monReg));
  // R9: illegal codes report internal type and no valid rate
  a_r9_illegal_out: assert property (@(posedge clk) disable iff (!rstN)
    illegalCode |-> (syncType == SYNC_INT) && !rateValid);
endmodule

// File: rtl/strobed_reg_bank.sv
module strobed_reg_bank
  import regbank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MON_W = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic [DATA_W-1:0] busData,
  input  logic busOeN,
  input  logic sysStbN,
  input  logic monStbN,
  input  logic clkStbN,
  output logic [DATA_W-1:0] sysCtrl,
  output logic [MON_W-1:0] monRoutes,
  output logic [DATA_W-1:0] clkCtrl,
  output logic [RATE_W-1:0] rateIdx,
  output logic rateValid,
  output logic [1:0] syncType,
  output logic illegalCode
);
  wrStrobe_t wr;
  logic [DATA_W-1:0] wrData;
  logic [NUM_STB-1:0] stbN;
  sync_e syncEnum;

  always_comb begin
    stbN[STB_SYS] = sysStbN;
    stbN[STB_MON] = monStbN;
    stbN[STB_CLK] = clkStbN;
  end

  regbank_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busData(busData), .busOeN(busOeN),
    .stbN(stbN), .wr(wr), .wrData(wrData)
  );

  regbank_dp #(.DATA_W(DATA_W), .MON_W(MON_W)) u_dp (
    .clk(clk), .rstN(rstN), .wr(wr), .wrData(wrData),
    .sysReg(sysCtrl), .monReg(monRoutes), .clkReg(clkCtrl),
    .rateIdx(rateIdx), .rateValid(rateValid), .syncType(syncEnum),
    .illegalCode(illegalCode)
  );

  assign syncType = syncEnum;
endmodule

// File: tb/strobed_reg_bank_bench.sv
module strobed_reg_bank_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busData = 8'hFF;
  logic busOeN = 1'b1;
  logic [2:0] stbN = 3'b111;
  logic [7:0] sysCtrl, clkCtrl;
  logic [5:0] monRoutes;
  logic [2:0] rateIdx;
  logic rateValid, illegalCode;
  logic [1:0] syncType;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  strobed_reg_bank u_strobed_reg_bank (
    .clk(clk), .rstN(rstN), .busData(busData), .busOeN(busOeN),
    .sysStbN(stbN[0]), .monStbN(stbN[1]), .clkStbN(stbN[2]),
    .sysCtrl(sysCtrl), .monRoutes(monRoutes), .clkCtrl(clkCtrl),
    .rateIdx(rateIdx), .rateValid(rateValid), .syncType(syncType),
    .illegalCode(illegalCode)
  );

  typedef struct packed {
    logic [7:0] d;
    logic oeN;
    logic [2:0] sN;
  } samp_t;

  samp_t hist[$];
  logic [7:0] mSys = 0, mMon = 0, mClk = 0;

  // Reference model: pin history, commit two samples after the release
  always @(posedge clk) begin
    if (!rstN) begin
      hist.delete();
      for (int i = 0; i < 4; i++) hist.push_front('{d: 8'h00, oeN: 1'b1, sN: 3'b111});
      mSys = 0; mMon = 0; mClk = 0;
    end else begin
      hist.push_front('{d: busData, oeN: busOeN, sN: stbN});
      if (hist.size() > 4) void'(hist.pop_back());
      for (int i = 0; i < 3; i++) begin
        if (hist[2].sN[i] && !hist[3].sN[i] && !hist[2].oeN) begin
          if (i == 0) mSys = hist[2].d;
          else if (i == 1) mMon = {2'b00, hist[2].d[5:0]};
          else mClk = hist[2].d;
        end
      end
    end
  end

  function automatic void decode(input logic [7:0] c, output int st, output int ill, output int rv);
    st = 0; ill = 0; rv = 0;
    if (!c[3]) begin
      rv = (c[2:0] <= 5) ? 1 : 0;
      ill = 1 - rv;
    end else if (c[4:0] == 5'b01000) st = 1;
    else if (c[4:0] == 5'b01010) st = 2;
    else if (c[4:0] == 5'b11010) st = 3;
    else ill = 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int st, ill, rv;
    decode(mClk, st, ill, rv);
    chk("R2/R4/R5 sysCtrl", sysCtrl, mSys);
    chk("R6 monRoutes", monRoutes, mMon[5:0]);
    chk("R2/R3 clkCtrl", clkCtrl, mClk);
    chk("R7 rateIdx", rateIdx, mClk[2:0]);
    chk("R7 rateValid", rateValid, rv);
    chk("R8 syncType", syncType, st);
    chk("R9 illegalCode", illegalCode, ill);
  end

  task automatic hostWrite(input int idx, input logic [7:0] val, input bit gate);
    @(negedge clk) busData = val;
    repeat (2) @(negedge clk);
    busOeN = gate ? 1'b0 : 1'b1;
    repeat (2) @(negedge clk);
    stbN[idx] = 1'b0;
    repeat (3) @(negedge clk);
    stbN[idx] = 1'b1;
    repeat (4) @(negedge clk);
    busOeN = 1'b1;
    busData = 8'hFF;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset sysCtrl", sysCtrl, 0);
    chk("R1 reset rateValid", rateValid, 1);
    chk("R1 reset syncType", syncType, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    hostWrite(0, 8'hA5, 1);
    chk("R5 sys write", sysCtrl, 8'hA5);
    hostWrite(1, 8'hFF, 1);
    chk("R6 mon drop top bits", monRoutes, 6'h3F);
    hostWrite(2, 8'h03, 1);
    chk("R7 rate 96k", rateIdx, 3);
    chk("R7 valid", rateValid, 1);
    chk("R4 sys untouched", sysCtrl, 8'hA5);
    hostWrite(0, 8'h00, 0);
    chk("R3 oe high ignored", sysCtrl, 8'hA5);

    // R2: exact commit cycle
    @(negedge clk) busData = 8'h5A; busOeN = 1'b0;
    repeat (2) @(negedge clk); stbN[0] = 1'b0;
    repeat (2) @(negedge clk); stbN[0] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 not yet after two edges", sysCtrl, 8'hA5);
    @(negedge clk);
    chk("R2 committed after third edge", sysCtrl, 8'h5A);
    busOeN = 1'b1;

    // R10: held low never writes
    @(negedge clk) busData = 8'h11; busOeN = 1'b0; stbN[1] = 1'b0;
    repeat (12) @(negedge clk);
    chk("R10 held low no write", monRoutes, 6'h3F);
    stbN[1] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 release writes", monRoutes, 6'h11);
    busOeN = 1'b1;

    hostWrite(2, 8'h08, 1);  chk("R8 spdif", syncType, 1);
    hostWrite(2, 8'h0A, 1);  chk("R8 wc1", syncType, 2);
    hostWrite(2, 8'h1A, 1);  chk("R8 wc256", syncType, 3);
    hostWrite(2, 8'hE8, 1);  chk("R8 upper bits free", syncType, 1);
    chk("R7 external not valid", rateValid, 0);
    hostWrite(2, 8'h18, 1);  chk("R9 bad external", illegalCode, 1);
    chk("R9 type internal", syncType, 0);
    hostWrite(2, 8'h06, 1);  chk("R9 rate 6", illegalCode, 1);
    hostWrite(2, 8'h0C, 1);  chk("R9 bad external 0C", illegalCode, 1);
    hostWrite(2, 8'h05, 1);  chk("R7 rate 192k", rateValid, 1);

    for (int n = 0; n < 60; n++) begin
      automatic int idx = $urandom_range(0, 2);
      automatic logic [7:0] v = 8'($urandom);
      if ($urandom_range(0, 3) == 0) v = {v[7:5], 5'b11010};
      hostWrite(idx, v, $urandom_range(0, 4) != 0);
    end
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      busData = 8'($urandom);
      busOeN = 1'($urandom);
      stbN = 3'($urandom);
    end
    stbN = 3'b111; busOeN = 1'b1;
    repeat (6) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule